// File: doc/BRIEF.md
# Sequential Signed Shift-and-Add Multiplier

This block multiplies two signed two's-complement operands of `N` bits each and returns a signed product of `2N` bits. It works on one multiplier bit per clock cycle. In each cycle it either adds the multiplicand into a running partial sum or leaves the partial sum unchanged. It then shifts the whole accumulator one place to the right, so the multiplicand never has to move.

The multiplier's top bit counts as minus 2^(N-1). For that reason the final step subtracts the sign-extended multiplicand instead of adding it. The right shift is arithmetic, so the partial sum keeps its sign. The upper accumulator half has one guard bit, which lets the most negative operand pairs form without wrap-around.

To use the block, pulse `start` while `busy` is low, with the operands present. The block captures them on that edge. `busy` then stays high for exactly `N` cycles. On the cycle after the last step, `done` pulses for one cycle, and from then on `product` holds the signed result until the next accepted start.

Top module: `mulSerialSigned`

## Requirements
- R1: While reset is asserted and right after it is released, `busy`, `done` and `product` are all zero.
- R2: A `start` seen at a clock edge while `busy` is low captures `a` and `b`, and `busy` reads high after that edge.
- R3: After an accepted start, `busy` stays high for exactly `N` cycles. `done` goes high for a single cycle in the first cycle in which `busy` reads low again.
- R4: When `done` is high, `product` equals the signed product of the captured operands as a `2N`-bit two's-complement value.
- R5: The multiplier's most significant bit carries weight -2^(N-1), so every negative `b` gives the correct signed result.
- R6: A `start`, or any change of `a` or `b`, while `busy` is high has no effect on timing or on the result of the operation in progress. This includes a `start` in the cycle of the final step.
- R7: While idle, `product` keeps the last result, whatever `a` and `b` do, until the next accepted start. An accepted start clears `product`.
- R8: The corner pairs come out exact. For example, the most negative value times itself gives +2^(2N-2), with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; accepted only while idle |
| a | input | N | Multiplicand, signed two's complement |
| b | input | N | Multiplier, signed two's complement |
| busy | output | 1 | High while the N steps are running |
| done | output | 1 | One-cycle pulse when the result becomes valid |
| product | output | 2N | Signed product, held while idle |

## Verification
Two events can meet in one cycle, and the bench provokes both. The first is a start request that lands in the cycle of the final step, while the block is still busy. That request must be dropped. The second is a start that lands in the `done` cycle. That start must be accepted at once, giving back-to-back operations, and it must clear the held product. The bench drives `start` at random during every operation and often right at the `done` cycle. A per-cycle reference model, kept in integers, judges `busy`, `done` and the held `product` against the rules on every clock.

// File: rtl/mulPkg.sv
package mulPkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operands, clear accumulator
    logic step;  // perform one add/shift step
    logic last;  // current step uses the sign bit of the multiplier
  } mulCtrlT;
endpackage

// File: rtl/mulCtrl.sv
module mulCtrl
  import mulPkg::*;
#(
  parameter int N = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output mulCtrlT ctrl,
  output logic    busy,
  output logic    done
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LastCnt = CW'(N - 1);

  logic          busyQ;
  logic          doneQ;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      cnt   <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (start) begin
          busyQ <= 1'b1;
          cnt   <= '0;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == LastCnt) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctrl.load = !busyQ && start;
    ctrl.step = busyQ;
    ctrl.last = busyQ && (cnt == LastCnt);
  end

  assign busy = busyQ;
  assign done = doneQ;

  // R2: an idle start is taken
  a_r2_start_taken: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);
  // R6: nothing but the final step ends an operation
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctrl.last) |=> busy);
  // R3: the final step is followed by done and idle
  a_r3_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.last |=> (done && !busy));
  // R3: done lasts one cycle
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R3: step counter stays within N steps
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(cnt) < N));
endmodule

// File: rtl/mulPath.sv
module mulPath
  import mulPkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  mulCtrlT        ctrl,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] product
);
  localparam int HW = N + 1;  // upper half with one guard bit

  logic [N-1:0]  mcand;
  logic [N-1:0]  mplier;
  logic [HW-1:0] accHi;
  logic [N-1:0]  accLo;
  logic [HW-1:0] addend;
  logic [HW-1:0] partSum;

  always_comb begin
    addend = {mcand[N-1], mcand};
    if (!mplier[0])      partSum = accHi;
    else if (ctrl.last)  partSum = accHi - addend;
    else                 partSum = accHi + addend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand  <= '0;
      mplier <= '0;
      accHi  <= '0;
      accLo  <= '0;
    end else if (ctrl.load) begin
      mcand  <= a;
      mplier <= b;
      accHi  <= '0;
      accLo  <= '0;
    end else if (ctrl.step) begin
      accHi  <= {partSum[HW-1], partSum[HW-1:1]};
      accLo  <= {partSum[0], accLo[N-1:1]};
      mplier <= {1'b0, mplier[N-1:1]};
    end
  end

  assign product = {accHi[N-1:0], accLo};

  // R7: idle without load keeps the product
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.step && !ctrl.load) |=> $stable(product));
  // R6: a load never coincides with a running step
  a_r6_no_load_in_step: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |-> !ctrl.load);
  // R7: an accepted start clears the product
  a_r7_load_clears: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (product == '0));
endmodule

// File: rtl/mulSerialSigned.sv
module mulSerialSigned
  import mulPkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  mulCtrlT ctrl;

  mulCtrl #(.N(N)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  mulPath #(.N(N)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .a       (a),
    .b       (b),
    .product (product)
  );
endmodule

// File: tb/test_mulSerialSigned.sv
`timescale 1ns/1ps
module test_mulSerialSigned;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN;
  logic        st4 = 1'b0, st8 = 1'b0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic        busy4, done4, busy8, done8;
  logic [7:0]  prod4;
  logic [15:0] prod8;

  mulSerialSigned #(.N(4)) i_mulSerialSigned4 (
    .clk(clk), .rstN(rstN), .start(st4), .a(a4), .b(b4),
    .busy(busy4), .done(done4), .product(prod4));

  mulSerialSigned #(.N(8)) i_mulSerialSigned (
    .clk(clk), .rstN(rstN), .start(st8), .a(a8), .b(b8),
    .busy(busy8), .done(done8), .product(prod8));

  int     checks = 0;
  int     fails = 0;
  int     rem[2];
  bit     expDone[2];
  longint expProd[2];
  int     la[2], lb[2];

  function automatic int wN(int sel);
    return (sel != 0) ? 8 : 4;
  endfunction

  function automatic int rndOp(int sel);
    int m;
    m = 1 << (wN(sel) - 1);
    return int'($urandom_range(2 * m - 1, 0)) - m;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: compare at negedge, drive, then advance the reference model
  task automatic cycle(int sel, bit st, int a, int b);
    bit     bz, dn;
    longint pr, mask;
    int     n, mn;
    string  tag;
    n    = wN(sel);
    mn   = -(1 << (n - 1));
    mask = (longint'(1) << (2 * n)) - 1;
    @(negedge clk);
    if (sel == 0) begin bz = busy4; dn = done4; pr = longint'(prod4); end
    else          begin bz = busy8; dn = done8; pr = longint'(prod8); end
    if (rem[sel] == n) tag = "R2";
    else if (rem[sel] > 0) tag = "R6";
    else tag = "R3";
    check(bz == (rem[sel] > 0), tag, "busy", longint'(bz), longint'(rem[sel] > 0));
    check(dn == expDone[sel], "R3", "done", longint'(dn), longint'(expDone[sel]));
    if (rem[sel] == 0) begin
      if (!expDone[sel]) tag = "R7";
      else if (la[sel] == mn && lb[sel] == mn) tag = "R8";
      else if (lb[sel] < 0) tag = "R5";
      else tag = "R4";
      check(pr == (expProd[sel] & mask), tag, "product", pr, expProd[sel] & mask);
    end
    if (sel == 0) begin st4 = st; a4 = a[3:0]; b4 = b[3:0]; end
    else          begin st8 = st; a8 = a[7:0]; b8 = b[7:0]; end
    @(posedge clk);
    if (rem[sel] > 0) begin
      rem[sel]--;
      expDone[sel] = (rem[sel] == 0);
      if (rem[sel] == 0) expProd[sel] = longint'(la[sel]) * longint'(lb[sel]);
    end else begin
      expDone[sel] = 1'b0;
      if (st) begin
        rem[sel] = n; la[sel] = a; lb[sel] = b; expProd[sel] = 0;
      end
    end
  endtask

  // finish the running operation with noisy inputs (R6), optional idle (R7), then start
  task automatic run(int sel, int a, int b);
    int k;
    while (rem[sel] != 0) cycle(sel, ($urandom % 3) == 0, rndOp(sel), rndOp(sel));
    k = $urandom % 3;
    repeat (k) cycle(sel, 1'b0, rndOp(sel), rndOp(sel));
    cycle(sel, 1'b1, a, b);
  endtask

  task automatic drain(int sel);
    while (rem[sel] != 0) cycle(sel, ($urandom % 3) == 0, rndOp(sel), rndOp(sel));
    repeat (3) cycle(sel, 1'b0, rndOp(sel), rndOp(sel));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      rem[i] = 0; expDone[i] = 1'b0; expProd[i] = 0; la[i] = 0; lb[i] = 0;
    end
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy4 == 1'b0 && busy8 == 1'b0, "R1", "busy", longint'(busy4 | busy8), 0);
    check(done4 == 1'b0 && done8 == 1'b0, "R1", "done", longint'(done4 | done8), 0);
    check(prod4 == '0, "R1", "product4", longint'(prod4), 0);
    check(prod8 == '0, "R1", "product8", longint'(prod8), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy4 == 1'b0 && done4 == 1'b0 && prod4 == '0, "R1", "after release",
          longint'(prod4), 0);

    // every signed pair for the narrow instance (R4, R5, R8)
    for (int x = -8; x < 8; x++)
      for (int y = -8; y < 8; y++)
        run(0, x, y);
    drain(0);

    // corners then random pairs for the wide instance
    run(1, -128, -128);
    run(1, -128, 127);
    run(1, 127, -128);
    run(1, 127, 127);
    run(1, 0, -128);
    run(1, -1, -1);
    run(1, -1, 1);
    for (int i = 0; i < 300; i++) run(1, rndOp(1), rndOp(1));
    drain(1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule